// File: doc/BRIEF.md
# Shift-Register Width Gearbox

This block re-packs a stream of narrow words into a stream of words of a different width on a single clock. Every accepted input word lands in a wide holding register. It is placed at a running bit position that marks how many valid bits are held. Output words are read from the low end of the register. Each time one leaves, the contents slide down by the output width and the held-bit count falls by the same amount. The bits therefore form one continuous little-endian stream: the first bit of the first input word becomes bit 0 of the first output word.

A per-word order control can mirror an input word before it is stored, so a source that sends its most significant bit first can be merged into the same stream. Both sides use a valid/ready handshake. The input side is gated only by free space, and the output side only by the number of held bits. Neither ready nor valid depends combinationally on the other side.

Top module: `width_gearbox`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1, so the held-bit count starts at zero.
- R2: `in_ready` is 1 exactly when the held-bit count plus `IN_W` does not exceed `BUF_W`.
- R3: `out_valid` is 1 exactly when the held-bit count is at least `OUT_W`.
- R4: Output words carry the concatenated input bit stream in order. Input word k, bit i (after any mirroring) is stream bit k*IN_W+i, and output word m, bit j is stream bit m*OUT_W+j.
- R5: When `in_rev` is 1 during an input handshake, stored bit i of that word equals `in_data[IN_W-1-i]`. When it is 0 the word is stored as given. The control applies to that word only.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` 1 with `out_data` unchanged.
- R7: An input handshake and an output handshake in the same cycle both take effect: the count changes by `IN_W - OUT_W` and no bit is lost or duplicated.
- R8: `in_valid` asserted while `in_ready` is 0 adds nothing to the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Room for one more input word |
| in_data | input | IN_W | Input word |
| in_rev | input | 1 | Mirror this input word before storing |
| out_valid | output | 1 | A full output word is held |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | OUT_W | Lowest OUT_W held bits |

## Verification
Every output is a register, so a handshake seen at one rising edge shows up in `in_ready`, `out_valid` and `out_data` at the very next edge. No output reacts combinationally to the inputs. The bench drives and samples only at falling edges. At each falling edge it compares the outputs with a bit-count model that was updated by the handshakes of the previous edge, and then decides the handshakes for the coming edge from the values just read. Output words are checked against a bit queue filled from the accepted inputs in the same step, so each result is compared exactly one edge after the handshakes that produced it.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  // Bits needed to count 0..buf_w held bits.
  function automatic int unsigned count_bits(int unsigned buf_w);
    return $clog2(buf_w + 1);
  endfunction

  // True when a word of word_w bits still fits above fill bits.
  function automatic logic word_fits(int unsigned fill, int unsigned word_w,
                                     int unsigned buf_w);
    return (fill + word_w) <= buf_w;
  endfunction

  // True when at least word_w bits are held.
  function automatic logic word_ready(int unsigned fill, int unsigned word_w);
    return fill >= word_w;
  endfunction
endpackage

// File: rtl/gbx_bit_order.sv
module gbx_bit_order #(
  parameter int unsigned W = 8
) (
  input  logic         mirror,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out
);
  for (genvar b = 0; b < W; b++) begin : g_lane
    assign word_out[b] = mirror ? word_in[W-1-b] : word_in[b];
  end
endmodule

// File: rtl/gbx_fill_ctrl.sv
module gbx_fill_ctrl
  import gbx_pkg::*;
#(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned BUF_W = 25,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_in,
  input  logic             give_out,
  output logic [CNT_W-1:0] fill,
  output logic             room,
  output logic             full_word
);
  logic [CNT_W-1:0] fill_next;

  always_comb begin
    fill_next = fill;
    if (take_in)  fill_next = fill_next + CNT_W'(IN_W);
    if (give_out) fill_next = fill_next - CNT_W'(OUT_W);
  end

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else     fill <= fill_next;
  end

  assign room      = word_fits(32'(fill), IN_W, BUF_W);
  assign full_word = word_ready(32'(fill), OUT_W);
endmodule

// File: rtl/gbx_shift_store.sv
module gbx_shift_store #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned BUF_W = 25,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_in,
  input  logic             give_out,
  input  logic [CNT_W-1:0] fill,
  input  logic [IN_W-1:0]  word,
  output logic [OUT_W-1:0] head
);
  logic [BUF_W-1:0] store_q;
  logic [BUF_W-1:0] store_d;
  logic [CNT_W-1:0] base;

  // Slide first, then place the new word at the post-slide position.
  always_comb begin
    store_d = give_out ? (store_q >> OUT_W) : store_q;
    base    = give_out ? (fill - CNT_W'(OUT_W)) : fill;
    if (take_in) store_d[base +: IN_W] = word;
  end

  always_ff @(posedge clk) begin
    if (rst) store_q <= '0;
    else     store_q <= store_d;
  end

  assign head = store_q[OUT_W-1:0];
endmodule

// File: rtl/width_gearbox.sv
module width_gearbox
  import gbx_pkg::*;
#(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned BUF_W = 3 * IN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_rev,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int unsigned CNT_W = count_bits(BUF_W);

  logic             take_in;
  logic             give_out;
  logic [CNT_W-1:0] fill;
  logic [IN_W-1:0]  ordered_word;

  assign take_in  = in_valid & in_ready;
  assign give_out = out_valid & out_ready;

  gbx_bit_order #(.W(IN_W)) u_order (
    .mirror  (in_rev),
    .word_in (in_data),
    .word_out(ordered_word)
  );

  gbx_fill_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_fill (
    .clk      (clk),
    .rst      (rst),
    .take_in  (take_in),
    .give_out (give_out),
    .fill     (fill),
    .room     (in_ready),
    .full_word(out_valid)
  );

  gbx_shift_store #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .take_in (take_in),
    .give_out(give_out),
    .fill    (fill),
    .word    (ordered_word),
    .head    (out_data)
  );
endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned BUF_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  localparam int unsigned CW = $clog2(BUF_W + 1) + 1;

  // Held-bit count rebuilt from port handshakes only.
  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else seen <= seen + ((in_valid && in_ready) ? CW'(IN_W) : '0)
                      - ((out_valid && out_ready) ? CW'(OUT_W) : '0);
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  assert_room_R2: assert property (@(posedge clk) disable iff (rst)
    in_ready == ((seen + CW'(IN_W)) <= CW'(BUF_W)));

  assert_word_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid == (seen >= CW'(OUT_W)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_both_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_valid && out_ready) |=> (seen <= CW'(BUF_W)));
endmodule

bind width_gearbox gbx_checker #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/sim_width_gearbox.sv
module sim_width_gearbox;
  localparam int IN_W  = 8;
  localparam int OUT_W = 12;
  localparam int BUF_W = 3 * IN_W + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IN_W-1:0]  in_data = '0;
  logic             in_rev = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [OUT_W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int held   = 0;          // model of held bits
  bit stream_q[$];         // scoreboard of expected bits
  logic             hold_pend = 1'b0;
  logic [OUT_W-1:0] hold_val  = '0;

  always #10 clk = ~clk;   // 50 MHz

  width_gearbox #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_rev(in_rev), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side: queue the bits of an accepted word.
  task automatic push_word(input logic [IN_W-1:0] d, input logic rv);
    for (int i = 0; i < IN_W; i++) stream_q.push_back(rv ? d[IN_W-1-i] : d[i]);
    held += IN_W;
  endtask

  // Monitor side: pop one output word and compare.
  task automatic pop_word(input logic [OUT_W-1:0] got);
    logic [OUT_W-1:0] exp;
    for (int j = 0; j < OUT_W; j++) exp[j] = stream_q.pop_front();
    chk(got === exp, "R4 R5 stream order", 32'(got), 32'(exp));
    held -= OUT_W;
  endtask

  task automatic step(input logic iv, input logic [IN_W-1:0] d,
                      input logic rv, input logic ordy);
    @(negedge clk);
    chk(out_valid === (held >= OUT_W), "R3 out_valid", 32'(out_valid), 32'(held >= OUT_W));
    chk(in_ready === (held + IN_W <= BUF_W), "R2 in_ready", 32'(in_ready),
        32'(held + IN_W <= BUF_W));
    if (hold_pend)
      chk(out_valid === 1'b1 && out_data === hold_val, "R6 hold", 32'(out_data), 32'(hold_val));
    in_valid  = iv;
    in_data   = d;
    in_rev    = rv;
    out_ready = ordy;
    if (out_valid && ordy) pop_word(out_data);      // R7 when both fire
    if (iv && in_ready) push_word(d, rv);           // R8: refused words never queued
    hold_pend = out_valid && !ordy;
    hold_val  = out_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset out_valid", 32'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 reset in_ready", 32'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset",
        {30'd0, out_valid, in_ready}, 32'd1);

    // Straight words, sink always ready
    for (int k = 0; k < 40; k++) step(1'b1, IN_W'(k * 37 + 5), 1'b0, 1'b1);
    // Mirrored words
    for (int k = 0; k < 20; k++) step(1'b1, IN_W'(8'h81 ^ (k * 13)), 1'b1, 1'b1);
    // Sink stalls: fill up, then offer words while full (R8, R6)
    for (int k = 0; k < 12; k++) step(1'b1, IN_W'(k + 8'h40), k[0], 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R8 full refuses", 32'(in_ready), 0);
      step(1'b1, 8'hFF, 1'b0, 1'b0);
    end
    // Random mix of valid, ready and order
    for (int k = 0; k < 300; k++)
      step(1'($urandom_range(0, 3) != 0), IN_W'($urandom), 1'($urandom),
           1'($urandom_range(0, 2) != 0));
    // Drain
    for (int k = 0; k < 10; k++) step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(held < OUT_W, "R3 drained", 32'(held), 32'(OUT_W - 1));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule